// File: doc/BRIEF.md
# Per-Thread Fetch Status Controller

This block tracks where each hardware thread of a multithreaded front end stands in its fetch life cycle. Each thread has one status value. The status moves in response to several inputs: stall pulses from four later pipeline stages, a global context-switch hold, redirect requests from the commit and decode stages, trap and quiesce events, and the handshake with the instruction cache. The cache handshake covers issuing a line request, a refusal, a retry and a returning line.

A squash loads a redirect address and pulses a valid flag for that thread. The same squash orphans any cache line the thread is still waiting for. A request the cache refuses is parked in one shared retry slot, and the cache path stays blocked while the slot is full. The block also drives a single stage-level active flag, so a clock-gating or activity unit can tell whether any thread can make progress.

Top module: `fetch_thread_ctl`

## Requirements
- R1: Status codes are RUN=0, IDLE=1, SQUASH=2, BLOCKED=3, WAIT_RESP=4, WAIT_RETRY=5, LINE_READY=6, TRAP=7, QUIESCE=8. Each thread's code sits in `status_o[4*t +: 4]`. Stall flag bit s*NTHR+t belongs to stage s (decode 0, rename 1, execute 2, commit 3) and thread t. A block pulse sets that bit and an unblock pulse clears it. `stall_o[t]` is the OR of the thread's four bits and `ctx_switch_i`. An unblock for a clear flag, or an unblock together with a block, is illegal.
- R2: A commit squash has the highest priority. On the next edge it gives SQUASH. It also pulses `redir_valid_o[t]`, with the redirect PC equal to the given address, the next PC at that address plus INST_BYTES, and the one after at plus twice INST_BYTES.
- R3: While the reorder buffer reports it is still squashing, the thread is held in SQUASH and no redirect is pulsed.
- R4: A decode squash is acted on, in the same way as R2, only when the thread is not already in SQUASH. Otherwise it has no effect, and the redirect valid flag and the redirect PC keep their values.
- R5: A stall seen in the current cycle (using the flags as updated by this cycle's pulses) moves the thread to BLOCKED, unless the thread is in WAIT_RESP, WAIT_RETRY, TRAP or QUIESCE. A BLOCKED or SQUASH thread with no stall and no event returns to RUN.
- R6: A line request is accepted only from RUN or LINE_READY, and only while the retry slot is empty. A refused request moves the thread to WAIT_RETRY and sets `cache_blocked_o`, with `retry_tid_o` naming the owner. A request made while the slot is full is ignored. An accepted request moves the thread to WAIT_RESP.
- R7: A retry with a successful resend moves the slot owner to WAIT_RESP and empties the slot. A retry whose resend fails changes nothing.
- R8: Each thread numbers its request attempts from 0, and the number is carried as the tag. A response whose tag matches the thread's outstanding request while the thread is in WAIT_RESP moves the thread to BLOCKED if it is stalled, and otherwise to LINE_READY. Every other response is dropped and adds one to `drop_cnt_o`.
- R9: A squash cancels the thread's outstanding request, so the late response is dropped. It also empties the retry slot if the thread owns it, which releases `cache_blocked_o`.
- R10: A LINE_READY thread stays there until it is selected to fetch. It then becomes RUN.
- R11: `active_o` is high when some active thread is in RUN, SQUASH or LINE_READY.
- R12: After reset every thread is IDLE, with no stall flags, no blocked cache and a drop count of zero. An inactive thread goes to IDLE, and an IDLE thread that is active becomes RUN.
- R13: A trap event moves a thread to TRAP, which only a squash from commit ends. A quiesce event moves a thread to QUIESCE, which a wake event ends by returning it to RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_i | input | 4*NTHR | Block pulses per stage and thread |
| unblk_i | input | 4*NTHR | Unblock pulses per stage and thread |
| ctx_switch_i | input | 1 | Global stall for a context switch |
| thread_active_i | input | NTHR | Thread enabled |
| cmt_squash_i | input | NTHR | Commit squash request |
| cmt_pc_i | input | NTHR*AW | Commit redirect address |
| rob_busy_i | input | NTHR | Reorder buffer still squashing |
| dec_squash_i | input | NTHR | Decode squash request |
| dec_pc_i | input | NTHR*AW | Decode redirect address |
| trap_i | input | NTHR | Trap event |
| quiesce_i | input | NTHR | Quiesce event |
| wake_i | input | NTHR | Wake from quiesce |
| fetch_sel_i | input | NTHR | Thread selected to fetch this cycle |
| miss_valid_i | input | 1 | Line request attempt |
| miss_tid_i | input | TIDW | Requesting thread |
| miss_ack_i | input | 1 | Cache accepted the request |
| miss_tag_o | output | TAGW | Tag the attempt carries |
| retry_i | input | 1 | Cache invites a resend |
| resend_ok_i | input | 1 | Resend accepted |
| resp_valid_i | input | 1 | Line response |
| resp_tid_i | input | TIDW | Response thread |
| resp_tag_i | input | TAGW | Response tag |
| status_o | output | 4*NTHR | Status per thread |
| stall_flags_o | output | 4*NTHR | Stall flags |
| stall_o | output | NTHR | Thread stalled |
| active_o | output | 1 | Stage active |
| cache_blocked_o | output | 1 | Retry slot full |
| retry_tid_o | output | TIDW | Retry slot owner |
| retry_tag_o | output | TAGW | Retry slot tag |
| drop_cnt_o | output | CNTW | Dropped responses |
| redir_valid_o | output | NTHR | Redirect pulse |
| redir_pc_o | output | NTHR*AW | Redirect PC |
| redir_npc_o | output | NTHR*AW | Redirect PC plus one instruction |
| redir_nnpc_o | output | NTHR*AW | Redirect PC plus two instructions |

## Verification
Stall handling is tried three ways: with a single stage's flag, with the global context-switch hold, and with a stall that arrives while a miss is parked or outstanding. Together these separate the R5 exemptions from the plain BLOCKED path. The squash sources are exercised on a thread that is already squashing and on one that is running, and this shows whether the decode squash is ignored or honoured. Cache traffic covers a refused-then-resent request, a wrong-tag response, a matching response under a stall and one without a stall, and responses and retries that arrive after a squash. These distinguish matched lines from orphaned ones and show when the retry slot is released.

// File: rtl/fetch_thread_ctl.sv
module fetch_thread_ctl #(
  parameter int NTHR       = 2,
  parameter int AW         = 32,
  parameter int INST_BYTES = 4,
  parameter int TAGW       = 4,
  parameter int CNTW       = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [4*NTHR-1:0]    blk_i,
  input  logic [4*NTHR-1:0]    unblk_i,
  input  logic                 ctx_switch_i,
  input  logic [NTHR-1:0]      thread_active_i,
  input  logic [NTHR-1:0]      cmt_squash_i,
  input  logic [NTHR*AW-1:0]   cmt_pc_i,
  input  logic [NTHR-1:0]      rob_busy_i,
  input  logic [NTHR-1:0]      dec_squash_i,
  input  logic [NTHR*AW-1:0]   dec_pc_i,
  input  logic [NTHR-1:0]      trap_i,
  input  logic [NTHR-1:0]      quiesce_i,
  input  logic [NTHR-1:0]      wake_i,
  input  logic [NTHR-1:0]      fetch_sel_i,
  input  logic                 miss_valid_i,
  input  logic [((NTHR>1)?$clog2(NTHR):1)-1:0] miss_tid_i,
  input  logic                 miss_ack_i,
  output logic [TAGW-1:0]      miss_tag_o,
  input  logic                 retry_i,
  input  logic                 resend_ok_i,
  input  logic                 resp_valid_i,
  input  logic [((NTHR>1)?$clog2(NTHR):1)-1:0] resp_tid_i,
  input  logic [TAGW-1:0]      resp_tag_i,
  output logic [4*NTHR-1:0]    status_o,
  output logic [4*NTHR-1:0]    stall_flags_o,
  output logic [NTHR-1:0]      stall_o,
  output logic                 active_o,
  output logic                 cache_blocked_o,
  output logic [((NTHR>1)?$clog2(NTHR):1)-1:0] retry_tid_o,
  output logic [TAGW-1:0]      retry_tag_o,
  output logic [CNTW-1:0]      drop_cnt_o,
  output logic [NTHR-1:0]      redir_valid_o,
  output logic [NTHR*AW-1:0]   redir_pc_o,
  output logic [NTHR*AW-1:0]   redir_npc_o,
  output logic [NTHR*AW-1:0]   redir_nnpc_o
);

  localparam int TIDW = (NTHR > 1) ? $clog2(NTHR) : 1;
  localparam int NSTG = 4;
  localparam int SW   = 4;
  localparam int NFLG = NSTG * NTHR;

  localparam logic [SW-1:0] ST_RUN     = 4'd0;
  localparam logic [SW-1:0] ST_IDLE    = 4'd1;
  localparam logic [SW-1:0] ST_SQUASH  = 4'd2;
  localparam logic [SW-1:0] ST_BLOCKED = 4'd3;
  localparam logic [SW-1:0] ST_WRESP   = 4'd4;
  localparam logic [SW-1:0] ST_WRETRY  = 4'd5;
  localparam logic [SW-1:0] ST_READY   = 4'd6;
  localparam logic [SW-1:0] ST_TRAP    = 4'd7;
  localparam logic [SW-1:0] ST_QUIESCE = 4'd8;

  logic [SW-1:0]   st_q      [NTHR];
  logic [SW-1:0]   st_d      [NTHR];
  logic [TAGW-1:0] tag_ctr_q [NTHR];
  logic [TAGW-1:0] tag_ctr_d [NTHR];
  logic [TAGW-1:0] out_tag_q [NTHR];
  logic [TAGW-1:0] out_tag_d [NTHR];
  logic [AW-1:0]   rpc_q     [NTHR];
  logic [AW-1:0]   rpc_d     [NTHR];

  logic [NFLG-1:0] flag_q, flag_d;
  logic [NTHR-1:0] stalled, kill, dec_eff, rv_q, rv_d;
  logic            slot_v_q, slot_v_d;
  logic [TIDW-1:0] slot_tid_q, slot_tid_d;
  logic [TAGW-1:0] slot_tag_q, slot_tag_d;
  logic [CNTW-1:0] drop_q;
  logic            issue_ok, resend, resp_hit;

  assign flag_d = blk_i | (flag_q & ~unblk_i);

  always_comb begin
    for (int t = 0; t < NTHR; t++) begin
      stalled[t] = ctx_switch_i;
      for (int s = 0; s < NSTG; s++) stalled[t] = stalled[t] | flag_d[s*NTHR+t];
      dec_eff[t] = thread_active_i[t] & dec_squash_i[t] & ~cmt_squash_i[t]
                 & ~rob_busy_i[t] & (st_q[t] != ST_SQUASH);
      kill[t]    = ~thread_active_i[t] | cmt_squash_i[t] | rob_busy_i[t] | dec_eff[t];
    end
  end

  assign issue_ok = miss_valid_i && !slot_v_q && !kill[miss_tid_i]
                 && (st_q[miss_tid_i] == ST_RUN || st_q[miss_tid_i] == ST_READY);
  assign resend   = retry_i && resend_ok_i && slot_v_q && !kill[slot_tid_q];
  assign resp_hit = resp_valid_i && !kill[resp_tid_i]
                 && st_q[resp_tid_i] == ST_WRESP
                 && resp_tag_i == out_tag_q[resp_tid_i];
  assign miss_tag_o = tag_ctr_q[miss_tid_i];

  always_comb begin
    for (int t = 0; t < NTHR; t++) begin
      st_d[t]      = st_q[t];
      tag_ctr_d[t] = tag_ctr_q[t];
      out_tag_d[t] = out_tag_q[t];
      rpc_d[t]     = rpc_q[t];
      rv_d[t]      = 1'b0;
      if (issue_ok && int'(miss_tid_i) == t) begin
        tag_ctr_d[t] = tag_ctr_q[t] + 1'b1;
        if (miss_ack_i) out_tag_d[t] = tag_ctr_q[t];
      end
      if (resend && int'(slot_tid_q) == t) out_tag_d[t] = slot_tag_q;
      if (!thread_active_i[t])                          st_d[t] = ST_IDLE;
      else if (cmt_squash_i[t]) begin
        st_d[t]  = ST_SQUASH;
        rv_d[t]  = 1'b1;
        rpc_d[t] = cmt_pc_i[t*AW +: AW];
      end
      else if (rob_busy_i[t])                           st_d[t] = ST_SQUASH;
      else if (dec_eff[t]) begin
        st_d[t]  = ST_SQUASH;
        rv_d[t]  = 1'b1;
        rpc_d[t] = dec_pc_i[t*AW +: AW];
      end
      else if (st_q[t] == ST_IDLE)                      st_d[t] = ST_RUN;
      else if (resp_hit && int'(resp_tid_i) == t)       st_d[t] = stalled[t] ? ST_BLOCKED : ST_READY;
      else if (issue_ok && int'(miss_tid_i) == t)       st_d[t] = miss_ack_i ? ST_WRESP : ST_WRETRY;
      else if (resend && int'(slot_tid_q) == t)         st_d[t] = ST_WRESP;
      else if (st_q[t] == ST_WRESP || st_q[t] == ST_WRETRY || st_q[t] == ST_TRAP)
                                                        st_d[t] = st_q[t];
      else if (st_q[t] == ST_QUIESCE)                   st_d[t] = wake_i[t] ? ST_RUN : ST_QUIESCE;
      else if (trap_i[t])                               st_d[t] = ST_TRAP;
      else if (quiesce_i[t])                            st_d[t] = ST_QUIESCE;
      else if (stalled[t])                              st_d[t] = ST_BLOCKED;
      else if (st_q[t] == ST_BLOCKED || st_q[t] == ST_SQUASH)
                                                        st_d[t] = ST_RUN;
      else if (st_q[t] == ST_READY && fetch_sel_i[t])   st_d[t] = ST_RUN;
    end
  end

  always_comb begin
    slot_v_d   = slot_v_q;
    slot_tid_d = slot_tid_q;
    slot_tag_d = slot_tag_q;
    if (slot_v_q && (kill[slot_tid_q] || resend)) slot_v_d = 1'b0;
    else if (issue_ok && !miss_ack_i) begin
      slot_v_d   = 1'b1;
      slot_tid_d = miss_tid_i;
      slot_tag_d = tag_ctr_q[miss_tid_i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < NTHR; t++) begin
        st_q[t]      <= ST_IDLE;
        tag_ctr_q[t] <= '0;
        out_tag_q[t] <= '0;
        rpc_q[t]     <= '0;
      end
      flag_q     <= '0;
      rv_q       <= '0;
      slot_v_q   <= 1'b0;
      slot_tid_q <= '0;
      slot_tag_q <= '0;
      drop_q     <= '0;
    end else begin
      for (int t = 0; t < NTHR; t++) begin
        st_q[t]      <= st_d[t];
        tag_ctr_q[t] <= tag_ctr_d[t];
        out_tag_q[t] <= out_tag_d[t];
        rpc_q[t]     <= rpc_d[t];
      end
      flag_q     <= flag_d;
      rv_q       <= rv_d;
      slot_v_q   <= slot_v_d;
      slot_tid_q <= slot_tid_d;
      slot_tag_q <= slot_tag_d;
      if (resp_valid_i && !resp_hit) drop_q <= drop_q + 1'b1;
    end
  end

  always_comb begin
    active_o = 1'b0;
    for (int t = 0; t < NTHR; t++)
      if (thread_active_i[t] &&
          (st_q[t] == ST_RUN || st_q[t] == ST_SQUASH || st_q[t] == ST_READY))
        active_o = 1'b1;
  end

  assign stall_flags_o   = flag_q;
  assign cache_blocked_o = slot_v_q;
  assign retry_tid_o     = slot_tid_q;
  assign retry_tag_o     = slot_tag_q;
  assign drop_cnt_o      = drop_q;
  assign redir_valid_o   = rv_q;

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    logic any_flag;
    always_comb begin
      any_flag = 1'b0;
      for (int s = 0; s < NSTG; s++) any_flag = any_flag | flag_q[s*NTHR+t];
    end
    assign stall_o[t]                = ctx_switch_i | any_flag;
    assign status_o[t*SW +: SW]      = st_q[t];
    assign redir_pc_o[t*AW +: AW]    = rpc_q[t];
    assign redir_npc_o[t*AW +: AW]   = rpc_q[t] + AW'(INST_BYTES);
    assign redir_nnpc_o[t*AW +: AW]  = rpc_q[t] + AW'(2*INST_BYTES);

    AST_CMT_SQUASH: assert property (@(posedge clk) disable iff (!rst_n)
      (thread_active_i[t] && cmt_squash_i[t]) |=> (st_q[t] == ST_SQUASH && rv_q[t])); // R2
    AST_ROB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (thread_active_i[t] && rob_busy_i[t] && !cmt_squash_i[t]) |=> (st_q[t] == ST_SQUASH && !rv_q[t])); // R3
    AST_DEC_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (thread_active_i[t] && dec_squash_i[t] && !cmt_squash_i[t] && st_q[t] == ST_SQUASH) |=> !rv_q[t]); // R4
    AST_RETRY_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[t] == ST_WRETRY) |-> (slot_v_q && slot_tid_q == TIDW'(t))); // R6
    AST_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !thread_active_i[t] |=> (st_q[t] == ST_IDLE)); // R12
  end

  for (genvar i = 0; i < NFLG; i++) begin : g_flg
    AST_UNBLOCK_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      unblk_i[i] |-> (flag_q[i] && !blk_i[i])); // R1
  end

  AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 (drop_q == $past(drop_q) || drop_q == CNTW'($past(drop_q) + 1'b1))); // R8

endmodule

// File: tb/fetch_thread_ctl_tb.sv
`timescale 1ns/1ps
module fetch_thread_ctl_tb;
  localparam int NTHR = 2;
  localparam int AW   = 32;
  localparam int TAGW = 4;
  localparam int CNTW = 8;

  localparam logic [31:0] RUN = 0, IDLE = 1, SQ = 2, BLK = 3, WRESP = 4,
                          WRETRY = 5, READY = 6, TRAP = 7, QUI = 8;
  localparam int K_ST = 0, K_STALL = 1, K_CB = 2, K_ACT = 3, K_DROP = 4,
                 K_RV = 5, K_PC = 6, K_NPC = 7, K_NNPC = 8, K_RTID = 9, K_FLG = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [4*NTHR-1:0] blk_i, unblk_i;
  logic ctx_switch_i;
  logic [NTHR-1:0] thread_active_i, cmt_squash_i, rob_busy_i, dec_squash_i;
  logic [NTHR-1:0] trap_i, quiesce_i, wake_i, fetch_sel_i;
  logic [NTHR*AW-1:0] cmt_pc_i, dec_pc_i;
  logic miss_valid_i, miss_ack_i, retry_i, resend_ok_i, resp_valid_i;
  logic [0:0] miss_tid_i, resp_tid_i, retry_tid_o;
  logic [TAGW-1:0] resp_tag_i, miss_tag_o, retry_tag_o;
  logic [4*NTHR-1:0] status_o, stall_flags_o;
  logic [NTHR-1:0] stall_o, redir_valid_o;
  logic active_o, cache_blocked_o;
  logic [CNTW-1:0] drop_cnt_o;
  logic [NTHR*AW-1:0] redir_pc_o, redir_npc_o, redir_nnpc_o;

  always #4 clk = ~clk;

  fetch_thread_ctl #(.NTHR(NTHR), .AW(AW), .INST_BYTES(4), .TAGW(TAGW), .CNTW(CNTW)) u_dut (
    .clk(clk), .rst_n(rst_n), .blk_i(blk_i), .unblk_i(unblk_i),
    .ctx_switch_i(ctx_switch_i), .thread_active_i(thread_active_i),
    .cmt_squash_i(cmt_squash_i), .cmt_pc_i(cmt_pc_i), .rob_busy_i(rob_busy_i),
    .dec_squash_i(dec_squash_i), .dec_pc_i(dec_pc_i), .trap_i(trap_i),
    .quiesce_i(quiesce_i), .wake_i(wake_i), .fetch_sel_i(fetch_sel_i),
    .miss_valid_i(miss_valid_i), .miss_tid_i(miss_tid_i), .miss_ack_i(miss_ack_i),
    .miss_tag_o(miss_tag_o), .retry_i(retry_i), .resend_ok_i(resend_ok_i),
    .resp_valid_i(resp_valid_i), .resp_tid_i(resp_tid_i), .resp_tag_i(resp_tag_i),
    .status_o(status_o), .stall_flags_o(stall_flags_o), .stall_o(stall_o),
    .active_o(active_o), .cache_blocked_o(cache_blocked_o),
    .retry_tid_o(retry_tid_o), .retry_tag_o(retry_tag_o), .drop_cnt_o(drop_cnt_o),
    .redir_valid_o(redir_valid_o), .redir_pc_o(redir_pc_o),
    .redir_npc_o(redir_npc_o), .redir_nnpc_o(redir_nnpc_o));

  typedef struct { int kind; int tid; logic [31:0] exp; int req; } item_t;
  item_t sb[$];
  int n_chk = 0, n_fail = 0;
  logic done = 1'b0;

  task automatic ex(int k, int t, logic [31:0] v, int r);
    item_t it;
    it.kind = k; it.tid = t; it.exp = v; it.req = r;
    sb.push_back(it);
  endtask

  task automatic clr();
    blk_i = '0; unblk_i = '0; ctx_switch_i = 0; cmt_squash_i = '0; rob_busy_i = '0;
    dec_squash_i = '0; trap_i = '0; quiesce_i = '0; wake_i = '0; fetch_sel_i = '0;
    miss_valid_i = 0; miss_tid_i = '0; miss_ack_i = 0; retry_i = 0; resend_ok_i = 0;
    resp_valid_i = 0; resp_tid_i = '0; resp_tag_i = '0;
  endtask

  task automatic step();
    @(negedge clk);
    clr();
  endtask

  function automatic logic [31:0] actual(int k, int t);
    case (k)
      K_ST:    return 32'(status_o[t*4 +: 4]);
      K_STALL: return 32'(stall_o[t]);
      K_CB:    return 32'(cache_blocked_o);
      K_ACT:   return 32'(active_o);
      K_DROP:  return 32'(drop_cnt_o);
      K_RV:    return 32'(redir_valid_o[t]);
      K_PC:    return redir_pc_o[t*AW +: AW];
      K_NPC:   return redir_npc_o[t*AW +: AW];
      K_NNPC:  return redir_nnpc_o[t*AW +: AW];
      K_RTID:  return 32'(retry_tid_o);
      default: return 32'(stall_flags_o);
    endcase
  endfunction

  initial begin : monitor
    forever begin
      @(posedge clk);
      #2;
      while (sb.size() > 0) begin
        item_t it;
        logic [31:0] a;
        it = sb.pop_front();
        a = actual(it.kind, it.tid);
        n_chk++;
        if (a !== it.exp) begin
          n_fail++;
          $display("FAIL R%0d kind %0d thread %0d: actual %0h expected %0h",
                   it.req, it.kind, it.tid, a, it.exp);
        end
      end
    end
  end

  initial begin : watchdog
    #(8*20000);
    if (!done) begin
      n_fail++;
      $display("FAIL R0 watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : driver
    clr();
    thread_active_i = '0; cmt_pc_i = '0; dec_pc_i = '0;
    repeat (2) @(negedge clk);
    // R12 reset state
    ex(K_ST,0,IDLE,12); ex(K_ST,1,IDLE,12); ex(K_CB,0,0,12); ex(K_DROP,0,0,12); ex(K_FLG,0,0,12);
    step();
    rst_n = 1'b1; thread_active_i = 2'b11;
    ex(K_ST,0,RUN,12); ex(K_ST,1,RUN,12); ex(K_ACT,0,1,11);
    step();
    // R1 R5 rename block on thread 0 (bit 1*2+0)
    blk_i[2] = 1;
    ex(K_ST,0,BLK,5); ex(K_STALL,0,1,1); ex(K_FLG,0,32'h4,1); ex(K_ST,1,RUN,5);
    step();
    ex(K_ST,0,BLK,5);
    step();
    unblk_i[2] = 1;
    ex(K_ST,0,RUN,5); ex(K_STALL,0,0,1); ex(K_FLG,0,0,1);
    step();
    // R1 context switch stalls every thread
    ctx_switch_i = 1;
    ex(K_ST,0,BLK,1); ex(K_ST,1,BLK,1); ex(K_STALL,1,1,1); ex(K_ACT,0,0,11);
    step();
    ex(K_ST,0,RUN,5); ex(K_ST,1,RUN,5);
    step();
    // R2 commit squash thread 1
    cmt_squash_i[1] = 1; cmt_pc_i[AW +: AW] = 32'h1000;
    ex(K_ST,1,SQ,2); ex(K_RV,1,1,2); ex(K_PC,1,32'h1000,2);
    ex(K_NPC,1,32'h1004,2); ex(K_NNPC,1,32'h1008,2); ex(K_RV,0,0,2);
    step();
    // R3 reorder buffer still squashing
    rob_busy_i[1] = 1;
    ex(K_ST,1,SQ,3); ex(K_RV,1,0,3);
    step();
    // R4 decode squash ignored while squashing
    dec_squash_i[1] = 1; dec_pc_i[AW +: AW] = 32'h2000;
    ex(K_RV,1,0,4); ex(K_PC,1,32'h1000,4); ex(K_ST,1,RUN,5);
    step();
    // R4 decode squash honoured from RUN
    dec_squash_i[1] = 1; dec_pc_i[AW +: AW] = 32'h2000;
    ex(K_ST,1,SQ,4); ex(K_RV,1,1,4); ex(K_PC,1,32'h2000,4); ex(K_NNPC,1,32'h2008,4);
    step();
    ex(K_ST,1,RUN,5);
    step();
    // R6 refused request, thread 0 tag 0
    miss_valid_i = 1; miss_tid_i = 0; miss_ack_i = 0;
    ex(K_ST,0,WRETRY,6); ex(K_CB,0,1,6); ex(K_RTID,0,0,6);
    step();
    // R6 request while slot full is ignored
    miss_valid_i = 1; miss_tid_i = 1; miss_ack_i = 1;
    ex(K_ST,1,RUN,6); ex(K_CB,0,1,6);
    step();
    // R5 stall does not move a retry-waiting thread (decode bit 0)
    blk_i[0] = 1;
    ex(K_ST,0,WRETRY,5); ex(K_STALL,0,1,1);
    step();
    // R7 failed resend
    retry_i = 1; resend_ok_i = 0;
    ex(K_ST,0,WRETRY,7); ex(K_CB,0,1,7);
    step();
    // R7 successful resend
    retry_i = 1; resend_ok_i = 1;
    ex(K_ST,0,WRESP,7); ex(K_CB,0,0,7);
    step();
    // R8 wrong tag dropped
    resp_valid_i = 1; resp_tid_i = 0; resp_tag_i = 4'd1;
    ex(K_DROP,0,1,8); ex(K_ST,0,WRESP,8);
    step();
    // R8 matching tag while stalled
    resp_valid_i = 1; resp_tid_i = 0; resp_tag_i = 4'd0;
    ex(K_ST,0,BLK,8); ex(K_DROP,0,1,8);
    step();
    unblk_i[0] = 1;
    ex(K_ST,0,RUN,5);
    step();
    miss_valid_i = 1; miss_tid_i = 0; miss_ack_i = 1;
    ex(K_ST,0,WRESP,6);
    step();
    // R8 matching tag 1 without stall
    resp_valid_i = 1; resp_tid_i = 0; resp_tag_i = 4'd1;
    ex(K_ST,0,READY,8); ex(K_ACT,0,1,11);
    step();
    // R10 waits for selection
    ex(K_ST,0,READY,10);
    step();
    fetch_sel_i[0] = 1;
    ex(K_ST,0,RUN,10);
    step();
    miss_valid_i = 1; miss_tid_i = 0; miss_ack_i = 1;
    ex(K_ST,0,WRESP,6);
    step();
    // R9 squash orphans the outstanding tag 2
    cmt_squash_i[0] = 1; cmt_pc_i[0 +: AW] = 32'h3000;
    ex(K_ST,0,SQ,9); ex(K_PC,0,32'h3000,2);
    step();
    resp_valid_i = 1; resp_tid_i = 0; resp_tag_i = 4'd2;
    ex(K_DROP,0,2,9); ex(K_ST,0,RUN,9);
    step();
    // R9 squash releases owned retry slot (thread 1 tag 0)
    miss_valid_i = 1; miss_tid_i = 1; miss_ack_i = 0;
    ex(K_ST,1,WRETRY,6); ex(K_RTID,0,1,6); ex(K_CB,0,1,6);
    step();
    dec_squash_i[1] = 1; dec_pc_i[AW +: AW] = 32'h4000;
    ex(K_ST,1,SQ,9); ex(K_CB,0,0,9);
    step();
    retry_i = 1; resend_ok_i = 1;
    ex(K_ST,1,RUN,9); ex(K_CB,0,0,9);
    step();
    // R13 trap
    trap_i[0] = 1;
    ex(K_ST,0,TRAP,13); ex(K_ACT,0,1,11);
    step();
    // R12 R11 deactivate thread 1
    thread_active_i = 2'b01;
    ex(K_ST,1,IDLE,12); ex(K_ST,0,TRAP,13); ex(K_ACT,0,0,11);
    step();
    ex(K_ST,0,TRAP,13);
    step();
    cmt_squash_i[0] = 1; cmt_pc_i[0 +: AW] = 32'h5000;
    ex(K_ST,0,SQ,13); ex(K_ACT,0,1,11);
    step();
    quiesce_i[0] = 1;
    ex(K_ST,0,QUI,13); ex(K_ACT,0,0,11);
    step();
    ex(K_ST,0,QUI,13);
    step();
    wake_i[0] = 1;
    ex(K_ST,0,RUN,13); ex(K_ACT,0,1,11);
    step();
    thread_active_i = 2'b11;
    ex(K_ST,1,RUN,12);
    step();
    step();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule